// File: doc/BRIEF.md
# UTOPIA Level 2 Transmit PHY Port

This block is the physical-layer end of a UTOPIA Level 2 transmit link for one port. An ATM-layer master polls it on a 5-bit address, selects it, and pushes 53-byte cells into it one byte per clock. The block holds these cells in a small cell buffer. The number of cell slots in that buffer is chosen at reset: two, three or four.

Polling returns two indications. The first shows room for one whole cell. It has a drive-enable so that the chip pads can float it when the address belongs to another port. The second shows room for two whole cells and is driven at all times. A start-of-cell flag opens every cell. A cell enters the buffer only once its last byte has arrived. If a new start-of-cell shows up part way through a cell, the partial cell is dropped and assembly starts again from the new cell. A downstream framer reads the stored cells one byte at a time through a pop interface.

Top module: `utx_phy_port`

## Requirements
- R1: While the synchronous active-low reset is held, `tx_clav`, `tx_clav_oe`, `tx_clav2`, `ovf_flag` and `pop_avail` are all 0 and the buffer is emptied.
- R2: `tx_clav_oe` is 1 in the cycle after `tx_addr` equals `cfg_port_addr` and 0 otherwise. When `tx_clav_oe` is 0, `tx_clav` is 0.
- R3: One cycle after a matching poll, `tx_clav` is 1 exactly when the free slots at that clock edge number at least one. Free slots are the depth, minus the cells stored, minus one if a cell is being assembled.
- R4: `tx_clav2` is 1 exactly when the free slots number at least two. It uses the same one-cycle timing as `tx_clav` and does not depend on the address.
- R5: A byte is taken only in a cycle where `tx_enb_n` is low and the port is selected. The port becomes selected when it sees its own address in a cycle with `tx_enb_n` high, and it stays selected until a cycle with `tx_enb_n` high carries another address.
- R6: An accepted byte with `tx_soc` high opens a new cell and is that cell's first byte. Accepted bytes that do not belong to an open cell are thrown away.
- R7: A cell is added to the buffer at the clock edge that takes its 53rd byte. `pop_avail` is 1 only while at least one complete cell is stored.
- R8: If `tx_soc` arrives while a cell is open, the bytes already collected for that cell are dropped. The new byte then starts a fresh cell.
- R9: The depth is loaded from `cfg_depth` only during reset. A value below 2 counts as 2, and a value above 4 counts as 4. Changing `cfg_depth` outside reset has no effect.
- R10: If a start-of-cell is accepted while every slot is taken by stored cells, that cell is discarded and `ovf_flag` is set. `ovf_flag` stays set until reset.
- R11: `pop_data` shows the oldest stored byte. A cycle with `pop` high and `pop_avail` high moves to the next byte. `pop_soc` is 1 exactly when the byte shown is the first byte of a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface and core clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the depth |
| cfg_port_addr | input | 5 | Address this port answers to |
| cfg_depth | input | 3 | Requested buffer depth in cells, sampled in reset |
| tx_addr | input | 5 | Poll and select address from the ATM layer |
| tx_enb_n | input | 1 | Active-low byte-valid enable |
| tx_soc | input | 1 | High on the first byte of a cell |
| tx_data | input | 8 | Cell byte |
| tx_clav | output | 1 | Space for one cell at the polled port |
| tx_clav_oe | output | 1 | Drive enable for `tx_clav` (address matched) |
| tx_clav2 | output | 1 | Space for two cells, always driven |
| ovf_flag | output | 1 | Sticky cell-dropped-for-lack-of-room flag |
| pop | input | 1 | Framer takes the shown byte |
| pop_avail | output | 1 | A complete cell is stored |
| pop_data | output | 8 | Oldest stored byte |
| pop_soc | output | 1 | Shown byte is the first of its cell |

## Verification
The assertions rely on three conditions. The reset is held low from time zero. `tx_enb_n` never goes low unless the port has first been selected with `tx_enb_n` high. `pop` is never raised to take more bytes than are stored. The stimulus uses tasks that always put a select cycle before a transfer and that pop only bytes already counted as stored. Some transfers are deliberately sent while the port is not selected, or without a start-of-cell. The stimulus also cuts cells short, polls other addresses, and keeps popping while cells arrive, so that buffer occupancy goes both up and down during a transfer.

// File: rtl/utx_pkg.sv
package utx_pkg;
   localparam int unsigned UTX_CELL_BYTES = 53;

   function automatic int utx_clamp(input int req, input int lo, input int hi);
      if (req < lo) return lo;
      if (req > hi) return hi;
      return req;
   endfunction
endpackage

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
   import utx_pkg::*;
#(
   parameter int unsigned MAX_CELLS  = 4,
   parameter int unsigned CELL_BYTES = UTX_CELL_BYTES,
   parameter int unsigned DATA_W     = 8,
   localparam int unsigned CNT_W     = $clog2(MAX_CELLS + 1),
   localparam int unsigned IDX_W     = $clog2(CELL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cfg_depth,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   input  logic              pop,
   output logic              pop_avail,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_soc,
   output logic [CNT_W-1:0]  free_slots
);
   localparam int unsigned SLOT_W = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
   localparam int unsigned MEM_N  = MAX_CELLS * CELL_BYTES;
   localparam int unsigned MEM_AW = $clog2(MEM_N);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

   if (MAX_CELLS < 2) begin : g_bad_cells
      $error("utx_cell_fifo: MAX_CELLS must be at least 2");
   end
   if (CELL_BYTES < 2) begin : g_bad_len
      $error("utx_cell_fifo: CELL_BYTES must be at least 2");
   end

   logic [DATA_W-1:0] mem [MEM_N];
   logic [CNT_W-1:0]  depth_q;
   logic [CNT_W-1:0]  held;
   logic [SLOT_W-1:0] wr_slot, rd_slot;
   logic [IDX_W-1:0]  rd_idx;
   logic [MEM_AW-1:0] waddr, raddr;
   logic              do_pop;

   function automatic logic [SLOT_W-1:0] slot_next(input logic [SLOT_W-1:0] s,
                                                   input logic [CNT_W-1:0] d);
      if ({{CNT_W{1'b0}}, s} + (CNT_W + SLOT_W)'(1) >= {{SLOT_W{1'b0}}, d})
         return '0;
      return s + SLOT_W'(1);
   endfunction

   assign waddr      = MEM_AW'(int'(wr_slot) * CELL_BYTES + int'(wr_idx));
   assign raddr      = MEM_AW'(int'(rd_slot) * CELL_BYTES + int'(rd_idx));
   assign pop_avail  = (held != '0);
   assign do_pop     = pop && pop_avail;
   assign pop_data   = mem[raddr];
   assign pop_soc    = pop_avail && (rd_idx == '0);
   assign free_slots = depth_q - held;

   // depth is latched only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) depth_q <= CNT_W'(utx_clamp(int'(cfg_depth), 2, int'(MAX_CELLS)));
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[waddr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held    <= '0;
         wr_slot <= '0;
         rd_slot <= '0;
         rd_idx  <= '0;
      end else begin
         if (commit) wr_slot <= slot_next(wr_slot, depth_q);
         if (do_pop) begin
            if (rd_idx == LAST_IDX) begin
               rd_idx  <= '0;
               rd_slot <= slot_next(rd_slot, depth_q);
            end else begin
               rd_idx <= rd_idx + IDX_W'(1);
            end
         end
         case ({commit, do_pop && (rd_idx == LAST_IDX)})
            2'b10:   held <= held + CNT_W'(1);
            2'b01:   held <= held - CNT_W'(1);
            default: held <= held;
         endcase
      end
   end

   a_r9_held_within_depth: assert property (@(posedge clk) disable iff (!rst_n)
      held <= depth_q);
   a_r7_commit_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (held < depth_q));
   a_r11_next_cell_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (do_pop && rd_idx == LAST_IDX) |=> (pop_soc == pop_avail));
   a_r9_depth_steady: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(depth_q));
endmodule

// File: rtl/utx_cell_asm.sv
module utx_cell_asm
   import utx_pkg::*;
#(
   parameter int unsigned MAX_CELLS  = 4,
   parameter int unsigned CELL_BYTES = UTX_CELL_BYTES,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 5,
   localparam int unsigned CNT_W     = $clog2(MAX_CELLS + 1),
   localparam int unsigned IDX_W     = $clog2(CELL_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_port_addr,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_enb_n,
   input  logic              tx_soc,
   input  logic [DATA_W-1:0] tx_data,
   input  logic [CNT_W-1:0]  free_slots,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              commit,
   output logic              in_prog,
   output logic              ovf_flag
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

   logic             sel_q;
   logic [IDX_W-1:0] idx_q;
   logic             take, room;

   assign take    = sel_q && !tx_enb_n;
   assign room    = (free_slots != '0);
   assign wr_en   = take && (tx_soc ? room : in_prog);
   assign wr_idx  = tx_soc ? '0 : idx_q;
   assign wr_data = tx_data;
   assign commit  = take && !tx_soc && in_prog && (idx_q == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         in_prog  <= 1'b0;
         idx_q    <= '0;
         ovf_flag <= 1'b0;
      end else begin
         if (tx_enb_n) sel_q <= (tx_addr == cfg_port_addr);
         if (take) begin
            if (tx_soc) begin
               // a start flag always restarts alignment; any partial cell is abandoned
               in_prog <= room;
               idx_q   <= IDX_W'(1);
               if (!room) ovf_flag <= 1'b1;
            end else if (in_prog) begin
               idx_q <= idx_q + IDX_W'(1);
               if (idx_q == LAST_IDX) in_prog <= 1'b0;
            end
         end
      end
   end

   a_r5_no_write_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tx_enb_n |-> !wr_en);
   a_r6_orphan_bytes_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !tx_soc) |-> in_prog);
   a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);
   a_r8_soc_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (take && tx_soc && room) |=> (in_prog && !commit));
endmodule

// File: rtl/utx_poll_resp.sv
module utx_poll_resp #(
   parameter int unsigned MAX_CELLS = 4,
   parameter int unsigned ADDR_W    = 5,
   localparam int unsigned CNT_W    = $clog2(MAX_CELLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_port_addr,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic [CNT_W-1:0]  free_slots,
   input  logic              in_prog,
   output logic              tx_clav,
   output logic              tx_clav_oe,
   output logic              tx_clav2
);
   logic [CNT_W-1:0] avail;
   logic             hit;

   assign avail = free_slots - CNT_W'(in_prog);
   assign hit   = (tx_addr == cfg_port_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_clav    <= 1'b0;
         tx_clav_oe <= 1'b0;
         tx_clav2   <= 1'b0;
      end else begin
         tx_clav_oe <= hit;
         tx_clav    <= hit && (avail >= CNT_W'(1));
         tx_clav2   <= (avail >= CNT_W'(2));
      end
   end

   a_r2_clav_quiet_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_clav_oe |-> !tx_clav);
   a_r4_two_implies_one: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_clav_oe && tx_clav2) |-> tx_clav);
   a_r3_reserved_slot: assert property (@(posedge clk) disable iff (!rst_n)
      in_prog |-> (free_slots != '0));
endmodule

// File: rtl/utx_phy_port.sv
module utx_phy_port
   import utx_pkg::*;
#(
   parameter int unsigned MAX_CELLS  = 4,
   parameter int unsigned CELL_BYTES = UTX_CELL_BYTES,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 5,
   localparam int unsigned CNT_W     = $clog2(MAX_CELLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_port_addr,
   input  logic [CNT_W-1:0]  cfg_depth,
   input  logic [ADDR_W-1:0] tx_addr,
   input  logic              tx_enb_n,
   input  logic              tx_soc,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_clav,
   output logic              tx_clav_oe,
   output logic              tx_clav2,
   output logic              ovf_flag,
   input  logic              pop,
   output logic              pop_avail,
   output logic [DATA_W-1:0] pop_data,
   output logic              pop_soc
);
   localparam int unsigned IDX_W = $clog2(CELL_BYTES);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("utx_phy_port: ADDR_W must be positive");
   end

   logic              wr_en, commit, in_prog;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [CNT_W-1:0]  free_slots;

   utx_cell_asm #(
      .MAX_CELLS(MAX_CELLS), .CELL_BYTES(CELL_BYTES),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) asm_i (
      .clk(clk), .rst_n(rst_n), .cfg_port_addr(cfg_port_addr),
      .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data),
      .free_slots(free_slots), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .commit(commit), .in_prog(in_prog), .ovf_flag(ovf_flag)
   );

   utx_cell_fifo #(
      .MAX_CELLS(MAX_CELLS), .CELL_BYTES(CELL_BYTES), .DATA_W(DATA_W)
   ) fifo_i (
      .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .commit(commit),
      .pop(pop), .pop_avail(pop_avail), .pop_data(pop_data), .pop_soc(pop_soc),
      .free_slots(free_slots)
   );

   utx_poll_resp #(
      .MAX_CELLS(MAX_CELLS), .ADDR_W(ADDR_W)
   ) poll_i (
      .clk(clk), .rst_n(rst_n), .cfg_port_addr(cfg_port_addr), .tx_addr(tx_addr),
      .free_slots(free_slots), .in_prog(in_prog),
      .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .tx_clav2(tx_clav2)
   );

   a_r1_reset_clean: assert property (@(posedge clk)
      !rst_n |=> (!pop_avail && !ovf_flag && !tx_clav && !tx_clav_oe && !tx_clav2));
endmodule

// File: tb/utx_phy_port_tb_top.sv
module utx_phy_port_tb_top;
   localparam int CB = 53;
   localparam logic [4:0] PORT  = 5'd9;
   localparam logic [4:0] OTHER = 5'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] cfg_port_addr = PORT;
   logic [2:0] cfg_depth = 3'd4;
   logic [4:0] tx_addr = OTHER;
   logic       tx_enb_n = 1'b1;
   logic       tx_soc = 1'b0;
   logic [7:0] tx_data = '0;
   logic       pop = 1'b0;
   logic       tx_clav, tx_clav_oe, tx_clav2, ovf_flag, pop_avail, pop_soc;
   logic [7:0] pop_data;

   int  n_chk = 0, n_bad = 0, cyc = 0;
   bit  pop_on = 1'b0;

   // reference model state
   int  m_depth = 4, m_ncells = 0, m_rdcnt = 0;
   bit  m_sel = 0, m_asm = 0, m_ovf = 0, started = 0;
   bit  e_clav = 0, e_oe = 0, e_clav2 = 0;
   byte unsigned m_part[$];
   byte unsigned m_q[$];

   always #5 clk = ~clk;

   utx_phy_port dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_port_addr(cfg_port_addr), .cfg_depth(cfg_depth),
      .tx_addr(tx_addr), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc), .tx_data(tx_data),
      .tx_clav(tx_clav), .tx_clav_oe(tx_clav_oe), .tx_clav2(tx_clav2),
      .ovf_flag(ovf_flag), .pop(pop), .pop_avail(pop_avail),
      .pop_data(pop_data), .pop_soc(pop_soc)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin : model
      int pre_n, avail;
      cyc++;
      if (!rst_n) begin
         m_depth = (cfg_depth < 2) ? 2 : (cfg_depth > 4) ? 4 : int'(cfg_depth);
         m_ncells = 0; m_rdcnt = 0; m_sel = 0; m_asm = 0; m_ovf = 0;
         e_clav = 0; e_oe = 0; e_clav2 = 0;
         m_part.delete(); m_q.delete();
         started = 1;
      end else begin
         pre_n = m_ncells;
         avail = m_depth - pre_n - (m_asm ? 1 : 0);
         e_oe = (tx_addr == PORT);
         e_clav = e_oe && (avail >= 1);
         e_clav2 = (avail >= 2);
         if (pop && pre_n > 0) begin
            void'(m_q.pop_front());
            m_rdcnt++;
            if (m_rdcnt == CB) begin m_rdcnt = 0; m_ncells--; end
         end
         if (m_sel && !tx_enb_n) begin
            if (tx_soc) begin
               m_part.delete();
               if (m_depth - pre_n > 0) begin m_asm = 1; m_part.push_back(tx_data); end
               else begin m_asm = 0; m_ovf = 1; end
            end else if (m_asm) begin
               m_part.push_back(tx_data);
               if (m_part.size() == CB) begin
                  foreach (m_part[i]) m_q.push_back(m_part[i]);
                  m_part.delete();
                  m_ncells++;
                  m_asm = 0;
               end
            end
         end
         if (tx_enb_n) m_sel = (tx_addr == PORT);
      end
   end

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         chk("R2 clav_oe", int'(tx_clav_oe), int'(e_oe));
         chk("R3 clav", int'(tx_clav), int'(e_clav));
         chk("R4 clav2", int'(tx_clav2), int'(e_clav2));
         chk("R10 ovf", int'(ovf_flag), int'(m_ovf));
         chk("R7 pop_avail", int'(pop_avail), int'(m_ncells > 0));
         if (m_ncells > 0) begin
            chk("R11 pop_data", int'(pop_data), int'(m_q[0]));
            chk("R11 pop_soc", int'(pop_soc), int'(m_rdcnt == 0));
         end
      end
   end

   task automatic drive(input logic [4:0] a, input logic en_n, input logic s, input logic [7:0] d);
      @(negedge clk);
      tx_addr = a; tx_enb_n = en_n; tx_soc = s; tx_data = d; pop = pop_on;
   endtask

   task automatic idle(input int n, input logic [4:0] a);
      for (int i = 0; i < n; i++) drive(a, 1'b1, 1'b0, 8'h00);
   endtask

   task automatic send(input logic [7:0] seed, input int nb, input bit with_soc, input bit do_sel);
      logic [4:0] a;
      a = do_sel ? PORT : OTHER;
      if (do_sel) drive(PORT, 1'b1, 1'b0, 8'h00);
      for (int i = 0; i < nb; i++) drive(a, 1'b0, with_soc && (i == 0), seed + 8'(i));
      drive(a, 1'b1, 1'b0, 8'h00);
   endtask

   task automatic pop_bytes(input int n);
      pop_on = 1'b1;
      idle(n, OTHER);
      pop_on = 1'b0;
      idle(1, OTHER);
   endtask

   task automatic do_reset(input logic [2:0] d);
      @(negedge clk);
      rst_n = 1'b0; cfg_depth = d;
      idle(2, OTHER);
      rst_n = 1'b1;
      idle(1, OTHER);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      @(negedge clk); @(negedge clk);
      chk("R1 clav in reset", int'(tx_clav), 0);
      chk("R1 clav_oe in reset", int'(tx_clav_oe), 0);
      chk("R1 clav2 in reset", int'(tx_clav2), 0);
      chk("R1 ovf in reset", int'(ovf_flag), 0);
      chk("R1 pop_avail in reset", int'(pop_avail), 0);
      rst_n = 1'b1;
      idle(2, OTHER);

      // unselected transfer is ignored
      send(8'h20, CB, 1'b1, 1'b0);
      chk("R5 unselected ignored", int'(pop_avail), 0);
      // bytes with no start flag are dropped
      send(8'h30, 10, 1'b0, 1'b1);
      chk("R6 orphan bytes", int'(pop_avail), 0);
      send(8'h10, CB, 1'b1, 1'b1);
      chk("R7 full cell stored", int'(pop_avail), 1);
      chk("R6 first byte", int'(pop_data), 8'h10);
      idle(2, OTHER);
      chk("R2 other address", int'(tx_clav_oe), 0);
      // spurious start flag mid-cell
      drive(PORT, 1'b1, 1'b0, 8'h00);
      for (int i = 0; i < 20; i++) drive(PORT, 1'b0, i == 0, 8'h40 + 8'(i));
      for (int i = 0; i < CB; i++) drive(PORT, 1'b0, i == 0, 8'h80 + 8'(i));
      drive(PORT, 1'b1, 1'b0, 8'h00);
      pop_bytes(CB);
      chk("R8 realigned head", int'(pop_data), 8'h80);
      chk("R8 realigned soc", int'(pop_soc), 1);
      pop_bytes(CB);
      chk("R8 single realigned cell", int'(pop_avail), 0);

      // fill depth 4 then overflow
      for (int c = 0; c < 4; c++) send(8'(c * 16), CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R3 full no clav", int'(tx_clav), 0);
      chk("R2 matched oe", int'(tx_clav_oe), 1);
      chk("R4 full no clav2", int'(tx_clav2), 0);
      send(8'hE0, CB, 1'b1, 1'b1);
      chk("R10 overflow set", int'(ovf_flag), 1);
      pop_bytes(4 * CB);
      chk("R10 overflow sticky", int'(ovf_flag), 1);
      chk("R10 dropped cell absent", int'(pop_avail), 0);

      // depth change without reset has no effect
      do_reset(3'd4);
      chk("R10 cleared by reset", int'(ovf_flag), 0);
      cfg_depth = 3'd2;
      for (int c = 0; c < 3; c++) send(8'(c + 1), CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R9 depth kept at 4 ovf", int'(ovf_flag), 0);
      chk("R9 depth kept at 4 clav", int'(tx_clav), 1);
      pop_bytes(3 * CB);

      do_reset(3'd2);
      send(8'h50, CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R9 depth2 one free clav", int'(tx_clav), 1);
      chk("R4 depth2 one free clav2", int'(tx_clav2), 0);
      send(8'h60, CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R9 depth2 full", int'(tx_clav), 0);
      send(8'h70, CB, 1'b1, 1'b1);
      chk("R9 depth2 overflow", int'(ovf_flag), 1);
      pop_bytes(2 * CB);

      do_reset(3'd3);
      for (int c = 0; c < 3; c++) send(8'(c + 9), CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R9 depth3 full", int'(tx_clav), 0);
      chk("R9 depth3 no ovf", int'(ovf_flag), 0);
      send(8'h90, CB, 1'b1, 1'b1);
      chk("R9 depth3 overflow", int'(ovf_flag), 1);
      pop_bytes(3 * CB);

      do_reset(3'd0);
      for (int c = 0; c < 2; c++) send(8'(c + 3), CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R9 low clamp to 2", int'(tx_clav), 0);
      pop_bytes(2 * CB);

      do_reset(3'd7);
      for (int c = 0; c < 3; c++) send(8'(c + 5), CB, 1'b1, 1'b1);
      idle(2, PORT);
      chk("R9 high clamp to 4", int'(tx_clav), 1);
      pop_bytes(3 * CB);

      // drain while filling
      do_reset(3'd2);
      pop_on = 1'b1;
      for (int c = 0; c < 5; c++) send(8'(c * 7), CB, 1'b1, 1'b1);
      idle(CB * 2 + 4, OTHER);
      pop_on = 1'b0;
      idle(2, OTHER);
      chk("R11 concurrent drain no ovf", int'(ovf_flag), 0);
      chk("R11 concurrent drain empty", int'(pop_avail), 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule